// File: doc/BRIEF.md
# Parallel Port Expander (Simple I/O and Bit Set/Reset)

This block hangs off a small processor bus and gives it three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves, a low nibble (bits 3:0) and a high nibble (bits 7:4), and each half has its own direction. The processor selects the block with an active-low chip select and picks one of four registers with a 2-bit address. It writes with an active-low write strobe and reads with an active-low read strobe over an 8-bit data bus. Each port pin group is brought out as separate input, output and output-enable buses, so that pad tristates can sit outside the block.

The control address takes two kinds of command, and bit 7 of the written byte tells them apart. With bit 7 at 1 the byte is a mode-set word. It sets the direction of port A, port B, C-low and C-high, and it clears every output latch. With bit 7 at 0 the byte is a single-bit command that sets or clears one bit of the port C output latch and leaves everything else unchanged. Output data is held in latches. Input pins are read live when the bus read happens and are never captured.

The strobes are sampled in the block's clock domain. A write takes effect on the clock edge at which the block sees the write strobe go from low to high while chip select is low. Read data is combinational from the address and the present state.

Top module: `ppx_expander`

## Requirements
- R1: After reset every output-enable bit is 0, every output latch holds 0, and a read of the control address returns 0x9B.
- R2: Address 00 selects port A, 01 port B, 10 port C and 11 the control register. A write commits only on the clock where the sampled write strobe rises (low in the previous cycle, high now) with chip select low. A strobe pulse with chip select high changes nothing.
- R3: In a mode-set word, bit 4 sets port A direction, bit 3 C-high, bit 1 port B and bit 0 C-low, and 1 means input. Each port's output-enable bits are all 1 when it is an output and all 0 when it is an input. Port C's enables follow each nibble separately.
- R4: A mode-set word clears all three output latches to 0.
- R5: A control byte with bit 7 at 0 writes bit 0 into the port C latch bit chosen by bits 3:1. Bits 6:4 are ignored. No other latch bit, no direction and no other port changes. For example, 0x09 sets bit 4 and 0x08 clears it.
- R6: A read of a port (or nibble of port C) that is an output returns the latched value. A read of an input returns the live pins, and those pins are never latched.
- R7: A read of the control address returns bit 7 as 1, the four direction bits at the positions of R3, and 0 in bits 6, 5 and 2.
- R8: The read-data enable is 1 exactly when chip select and read strobe are both low. The read data is 0 whenever the enable is 0.
- R9: Control word 0x80 makes every port an output, so all output enables become 1 and all latches become 0.
- R10: A write to a port address loads that port's latch even while the port is an input. The value appears on its output bus, but the output-enable bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus |
| rdata_oe | output | 1 | Drive enable for the read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, per nibble |

## Verification
The state inside the block is small: four direction bits and three 8-bit latches. Each of these is visible at the ports in the clock cycle after the write that sets it. A wrong direction bit shows up at once as a wrong output-enable group and as a read that returns pins where it should return the latch (or the reverse). A missed clear or a bit command that lands on the wrong index shows up at once on pc_out. The bench therefore compares all latch and enable outputs after every write, and compares every read against a model. A wrong internal value is reported in the cycle after the write that exposes it.

// File: rtl/ppx_pkg.sv
// Shared types and helpers for the parallel port expander.
// Assumes an 8-bit bus and a 2-bit register select.
package ppx_pkg;

    localparam int BUS_W   = 8;
    localparam int SEL_W   = 2;
    localparam int NIB_W   = BUS_W / 2;
    localparam int BIDX_W  = $clog2(BUS_W);

    typedef enum logic [SEL_W-1:0] {
        SEL_PA  = 2'b00,
        SEL_PB  = 2'b01,
        SEL_PC  = 2'b10,
        SEL_CTL = 2'b11
    } ppx_sel_e;

    // Direction flags, 1 means the group is an input.
    typedef struct packed {
        logic a_in;
        logic ch_in;
        logic b_in;
        logic cl_in;
    } ppx_dir_t;

    localparam ppx_dir_t DIR_AT_RESET = '{a_in: 1'b1, ch_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

    // Control byte positions that the processor depends on.
    localparam int CW_KIND_BIT = 7;
    localparam int CW_A_BIT    = 4;
    localparam int CW_CH_BIT   = 3;
    localparam int CW_B_BIT    = 1;
    localparam int CW_CL_BIT   = 0;

    // Pull the direction flags out of a mode-set byte.
    function automatic ppx_dir_t dir_from_word(input logic [BUS_W-1:0] w);
        ppx_dir_t d;
        d.a_in  = w[CW_A_BIT];
        d.ch_in = w[CW_CH_BIT];
        d.b_in  = w[CW_B_BIT];
        d.cl_in = w[CW_CL_BIT];
        return d;
    endfunction

    // Rebuild the readable control byte from the direction flags.
    function automatic logic [BUS_W-1:0] word_from_dir(input ppx_dir_t d);
        logic [BUS_W-1:0] w;
        w              = '0;
        w[CW_KIND_BIT] = 1'b1;
        w[CW_A_BIT]    = d.a_in;
        w[CW_CH_BIT]   = d.ch_in;
        w[CW_B_BIT]    = d.b_in;
        w[CW_CL_BIT]   = d.cl_in;
        return w;
    endfunction

endpackage

// File: rtl/ppx_bus_if.sv
// Bus front end: samples the write strobe and produces a one-cycle commit
// pulse on the cycle in which the strobe is seen rising with chip select low.
// Assumes the strobes are already synchronous to clk and that address and
// data are steady on the commit cycle.
module ppx_bus_if
    import ppx_pkg::*;
#(
    parameter int DATA_W = BUS_W,
    parameter int ADDR_W = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output ppx_sel_e          commit_sel,
    output logic [DATA_W-1:0] commit_data
);

    logic wr_n_q;

    // Remember the strobe level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
        end
    end

    // Rising strobe while selected is a register write.
    always_comb begin
        commit      = !wr_n_q && wr_n && !cs_n;
        commit_sel  = ppx_sel_e'(addr);
        commit_data = wdata;
    end

endmodule

// File: rtl/ppx_ctrl.sv
// Control register: holds the direction flags and splits a control write
// into a mode-set or a single-bit command for port C.
// Assumes commit is a one-cycle pulse from the bus front end.
module ppx_ctrl
    import ppx_pkg::*;
#(
    parameter int DATA_W = BUS_W,
    parameter int IDX_W  = BIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  ppx_sel_e          commit_sel,
    input  logic [DATA_W-1:0] commit_data,
    output ppx_dir_t          dir,
    output logic              mode_load,
    output logic              bit_load,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              bit_val
);

    logic ctl_hit;

    // Decode which of the two command kinds this write carries.
    always_comb begin
        ctl_hit   = commit && (commit_sel == SEL_CTL);
        mode_load = ctl_hit && commit_data[CW_KIND_BIT];
        bit_load  = ctl_hit && !commit_data[CW_KIND_BIT];
        bit_idx   = commit_data[IDX_W:1];
        bit_val   = commit_data[0];
    end

    // Direction flags change only on a mode-set word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_AT_RESET;
        end else if (mode_load) begin
            dir <= dir_from_word(commit_data);
        end
    end

endmodule

// File: rtl/ppx_out_latch.sv
// Output latch for one port. It loads a whole byte, changes a single bit,
// or clears to zero. A clear wins over everything else, and a whole-byte
// load wins over a single-bit change. Assumes at most one of these
// requests is active in any cycle during normal use.
module ppx_out_latch #(
    parameter int WIDTH    = 8,
    parameter bit HAS_BITS = 1'b0,
    localparam int IDX_W   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             bit_load,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] nxt;

    // Work out the next latch value from the request.
    generate
        if (HAS_BITS) begin : g_bits
            always_comb begin
                nxt = q;
                if (clr) begin
                    nxt = '0;
                end else if (load) begin
                    nxt = load_data;
                end else if (bit_load) begin
                    nxt[bit_idx] = bit_val;
                end
            end
        end else begin : g_plain
            logic unused_bits;
            assign unused_bits = bit_load ^ bit_val ^ (^bit_idx);
            always_comb begin
                nxt = q;
                if (clr) begin
                    nxt = '0;
                end else if (load) begin
                    nxt = load_data;
                end
            end
        end
    endgenerate

    // Hold the latched output value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/ppx_rd_mux.sv
// Read path. It picks the latch for a group that is an output and the live
// pins for a group that is an input. Port C is chosen nibble by nibble.
// The output is zero when the bus is not reading. Purely combinational.
module ppx_rd_mux
    import ppx_pkg::*;
#(
    parameter int DATA_W = BUS_W,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  ppx_sel_e          sel,
    input  ppx_dir_t          dir,
    input  logic [DATA_W-1:0] a_latch,
    input  logic [DATA_W-1:0] b_latch,
    input  logic [DATA_W-1:0] c_latch,
    input  logic [DATA_W-1:0] a_pins,
    input  logic [DATA_W-1:0] b_pins,
    input  logic [DATA_W-1:0] c_pins,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    logic [DATA_W-1:0] a_view;
    logic [DATA_W-1:0] b_view;
    logic [DATA_W-1:0] c_view;
    logic [DATA_W-1:0] picked;

    // Per-group view: pins when input, latch when output.
    always_comb begin
        a_view = dir.a_in ? a_pins : a_latch;
        b_view = dir.b_in ? b_pins : b_latch;
        c_view[HALF_W-1:0]      = dir.cl_in ? c_pins[HALF_W-1:0] : c_latch[HALF_W-1:0];
        c_view[DATA_W-1:HALF_W] = dir.ch_in ? c_pins[DATA_W-1:HALF_W] : c_latch[DATA_W-1:HALF_W];
    end

    // Register select for the read.
    always_comb begin
        unique case (sel)
            SEL_PA:  picked = a_view;
            SEL_PB:  picked = b_view;
            SEL_PC:  picked = c_view;
            default: picked = word_from_dir(dir);
        endcase
    end

    // Gate the data onto the bus only during a selected read.
    always_comb begin
        rdata_oe = !cs_n && !rd_n;
        rdata    = rdata_oe ? picked : '0;
    end

endmodule

// File: rtl/ppx_expander.sv
// Top level of the parallel port expander: bus front end, control register,
// three output latches and the read path. All ports are in simple I/O mode.
// Port C also takes single-bit set/clear commands.
// Assumes synchronous strobes and a synchronous active-low reset.
module ppx_expander
    import ppx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [SEL_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             rdata_oe,
    input  logic [BUS_W-1:0] pa_in,
    output logic [BUS_W-1:0] pa_out,
    output logic [BUS_W-1:0] pa_oe,
    input  logic [BUS_W-1:0] pb_in,
    output logic [BUS_W-1:0] pb_out,
    output logic [BUS_W-1:0] pb_oe,
    input  logic [BUS_W-1:0] pc_in,
    output logic [BUS_W-1:0] pc_out,
    output logic [BUS_W-1:0] pc_oe
);

    localparam int NPORT = 3;

    logic              commit;
    ppx_sel_e          commit_sel;
    logic [BUS_W-1:0]  commit_data;
    ppx_dir_t          dir;
    logic              mode_load;
    logic              bit_load;
    logic [BIDX_W-1:0] bit_idx;
    logic              bit_val;
    logic [BUS_W-1:0]  latch_q [NPORT];

    ppx_bus_if u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wr_n        (wr_n),
        .addr        (addr),
        .wdata       (wdata),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data)
    );

    ppx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .dir         (dir),
        .mode_load   (mode_load),
        .bit_load    (bit_load),
        .bit_idx     (bit_idx),
        .bit_val     (bit_val)
    );

    // One latch per port; only port C (index 2) takes single-bit commands.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam bit IS_C = (p == 2);
            logic hit;
            assign hit = commit && (commit_sel == ppx_sel_e'(p));
            ppx_out_latch #(
                .WIDTH    (BUS_W),
                .HAS_BITS (IS_C)
            ) u_latch (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (mode_load),
                .load      (hit),
                .load_data (commit_data),
                .bit_load  (IS_C ? bit_load : 1'b0),
                .bit_idx   (bit_idx),
                .bit_val   (bit_val),
                .q         (latch_q[p])
            );
        end
    endgenerate

    // Drive latches and enables out; enables follow direction per group.
    always_comb begin
        pa_out = latch_q[0];
        pb_out = latch_q[1];
        pc_out = latch_q[2];
        pa_oe  = {BUS_W{!dir.a_in}};
        pb_oe  = {BUS_W{!dir.b_in}};
        pc_oe  = {{NIB_W{!dir.ch_in}}, {NIB_W{!dir.cl_in}}};
    end

    ppx_rd_mux u_rd (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .sel      (ppx_sel_e'(addr)),
        .dir      (dir),
        .a_latch  (latch_q[0]),
        .b_latch  (latch_q[1]),
        .c_latch  (latch_q[2]),
        .a_pins   (pa_in),
        .b_pins   (pb_in),
        .c_pins   (pc_in),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

endmodule

// File: rtl/ppx_checker.sv
// Port-level properties of the expander, bound into every instance.
// Keeps its own copy of the write strobe history to spot commits.
module ppx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);

    logic wr_seen_low;
    logic wr_go;
    logic ctl_wr;

    // Previous strobe level, seen independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_low <= 1'b0;
        end else begin
            wr_seen_low <= !wr_n;
        end
    end

    assign wr_go  = wr_seen_low && wr_n && !cs_n;
    assign ctl_wr = wr_go && (addr == 2'b11);

    // R1: first active cycle shows the reset state.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                          pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R2: nothing changes in the cycle after a cycle with no commit.
    assert_no_commit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable({pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe}));

    // R3: enables move only after a mode-set word.
    assert_oe_only_on_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && wdata[7]) |=> $stable({pa_oe, pb_oe, pc_oe}));

    // R4: a mode-set word leaves every latch at zero.
    assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R5: a bit command touches at most one bit of port C and nothing else.
    assert_bit_cmd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                                   $stable(pa_out) && $stable(pb_out) &&
                                   $stable({pa_oe, pb_oe, pc_oe})));

    // R8: the read bus is quiet unless selected for a read.
    assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!rdata_oe && rdata == 8'h00));

endmodule

bind ppx_expander ppx_checker u_ppx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .pb_out   (pb_out),
    .pb_oe    (pb_oe),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe)
);

// File: tb/ppx_expander_bench.sv
`timescale 1ns/1ps
module ppx_expander_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model of the block's visible state.
    logic [7:0] m_a, m_b, m_c;
    logic       d_a, d_ch, d_b, d_cl;   // 1 = input

    always #2.5 clk = ~clk;

    ppx_expander u_ppx_expander (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'b00: return d_a ? pa_in : m_a;
            2'b01: return d_b ? pb_in : m_b;
            2'b10: return {d_ch ? pc_in[7:4] : m_c[7:4], d_cl ? pc_in[3:0] : m_c[3:0]};
            default: return {1'b1, 2'b00, d_a, d_ch, 1'b0, d_b, d_cl};
        endcase
    endfunction

    function automatic logic [7:0] exp_oe(input logic [1:0] p);
        case (p)
            2'b00: return {8{~d_a}};
            2'b01: return {8{~d_b}};
            default: return {{4{~d_ch}}, {4{~d_cl}}};
        endcase
    endfunction

    // Update the model for a committed write.
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'b00: m_a = d;
            2'b01: m_b = d;
            2'b10: m_c = d;
            default: begin
                if (d[7]) begin
                    d_a = d[4]; d_ch = d[3]; d_b = d[1]; d_cl = d[0];
                    m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    // Strobe pulse; commit happens at the edge where wr_n is seen high.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_low);
        @(negedge clk);
        cs_n = ~sel_low; addr = a; wdata = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        if (sel_low) model_write(a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = rdata; oe = rdata_oe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic chk_pins(input string req);
        chk(req, "pa_out", pa_out, m_a);
        chk(req, "pb_out", pb_out, m_b);
        chk(req, "pc_out", pc_out, m_c);
        chk(req, "pa_oe", pa_oe, exp_oe(2'b00));
        chk(req, "pb_oe", pb_oe, exp_oe(2'b01));
        chk(req, "pc_oe", pc_oe, exp_oe(2'b10));
    endtask

    task automatic chk_read(input string req, input logic [1:0] a);
        logic [7:0] d;
        logic oe;
        bus_read(a, d, oe);
        chk(req, "rdata_oe", {7'b0, oe}, 8'h01);
        chk(req, $sformatf("read addr %0d", a), d, exp_read(a));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic oe;
        void'($urandom(32'd20240611));
        m_a = 0; m_b = 0; m_c = 0;
        d_a = 1; d_ch = 1; d_b = 1; d_cl = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_pins("R1");
        pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h5A;
        bus_read(2'b11, d, oe);
        chk("R1", "ctl after reset", d, 8'h9B);

        // R8: idle bus and deselected read stay quiet
        @(negedge clk); rd_n = 1'b0; cs_n = 1'b1; #1;
        chk("R8", "rdata deselected", rdata, 8'h00);
        chk("R8", "oe deselected", {7'b0, rdata_oe}, 8'h00);
        rd_n = 1'b1;

        // R10: write to an input port loads latch, enables stay low
        bus_write(2'b00, 8'hA5, 1'b1);
        chk_pins("R10");
        chk_read("R6", 2'b00);

        // R9: all outputs
        bus_write(2'b11, 8'h80, 1'b1);
        chk_pins("R9");
        chk("R9", "pa_out cleared", pa_out, 8'h00);

        // R2 and R6: address map and output read-back
        bus_write(2'b00, 8'h55, 1'b1);
        bus_write(2'b01, 8'hAA, 1'b1);
        bus_write(2'b10, 8'h3C, 1'b1);
        chk_pins("R2");
        chk_read("R6", 2'b00);
        chk_read("R6", 2'b01);
        chk_read("R6", 2'b10);

        // R2: pulse with chip select high changes nothing
        bus_write(2'b01, 8'h11, 1'b0);
        chk("R2", "pb_out unselected", pb_out, 8'hAA);
        bus_write(2'b11, 8'h9B, 1'b0);
        chk("R2", "pa_oe unselected", pa_oe, 8'hFF);

        // R5: 0x09 sets bit 4, 0x08 clears it, 0x7F sets bit 7 (bits 6:4 ignored)
        bus_write(2'b11, 8'h09, 1'b1);
        chk("R5", "set bit4", pc_out, 8'h3C | 8'h10);
        bus_write(2'b11, 8'h08, 1'b1);
        chk("R5", "clear bit4", pc_out, 8'h2C);
        bus_write(2'b11, 8'h7F, 1'b1);
        chk("R5", "bit7 via 0x7F", pc_out, 8'hAC);
        chk_pins("R5");

        // R4: mode word clears latches
        bus_write(2'b11, 8'h80, 1'b1);
        chk("R4", "pc_out cleared", pc_out, 8'h00);
        chk_pins("R4");

        // R3, R6, R7: A and C-low in, B and C-high out
        bus_write(2'b11, 8'h91, 1'b1);
        chk_pins("R3");
        bus_write(2'b10, 8'hF0, 1'b1);
        pc_in = 8'h0F;
        chk_read("R6", 2'b10);
        chk_read("R6", 2'b00);
        bus_read(2'b11, d, oe);
        chk("R7", "ctl 0x91", d, 8'h91);

        // R7: mode bits 6:5 and 2 read back as zero
        bus_write(2'b11, 8'hE4, 1'b1);
        bus_read(2'b11, d, oe);
        chk("R7", "ctl 0xE4", d, 8'h80);
        chk_pins("R3");

        // Random mix of writes, pin changes and reads
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] v;
            int op;
            op = $urandom_range(0, 3);
            a  = 2'($urandom_range(0, 3));
            v  = 8'($urandom);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            if (op == 0) begin
                bus_write(a, v, 1'b1);
                chk_pins(a == 2'b11 ? (v[7] ? "R3" : "R5") : "R2");
            end else if (op == 1) begin
                bus_write(2'b11, {1'b0, v[6:0]}, 1'b1);
                chk_pins("R5");
            end else begin
                chk_read(a == 2'b11 ? "R7" : "R6", a);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule